// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-up to the idle state. After reset it leaves the command bus deselected until a stable-power indication arrives. It then holds NOP for a settling interval whose length comes from the clock frequency and the required wait in microseconds. Next it issues a precharge of all banks, the extended mode register write, the mode register write and a run of auto-refresh commands. It closes with a fixed hold of quiet cycles and then raises a ready flag, which the normal controller logic uses as permission to take over the bus.

The mode register word is built from configuration inputs: burst length, burst type, CAS latency code and DLL reset. Reserved burst-length and latency codes raise a configuration error. While that error is present the sequencer will not write the mode register and holds NOP at that step. The block also reports the read latency the data path must expect, counted in half clock cycles, including one extra clock when the module is a registered one.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset until `pwrStable` is sampled high, the bus shows deselect (`csN`=1), `ready` is 0 and no command is issued.
- R2: After `pwrStable` is sampled high, NOP ({csN,rasN,casN,weN}=0111) is driven for exactly CLK_MHZ*SETTLE_US cycles, and the precharge-all command follows in the next cycle.
- R3: The only commands issued are, in this order: precharge-all (0010 with `addr[10]`=1), extended mode write (0000, `ba`=01, `addr`=0), mode write (0000, `ba`=00), then max(2, REFRESH_COUNT) auto-refreshes (0001). Every other cycle carries NOP.
- R4: The extended mode write comes T_RP cycles after the precharge. The mode write comes T_MRD cycles after the extended write when the configuration is valid. The first refresh comes T_MRD cycles after the mode write, and successive refreshes are T_RFC cycles apart.
- R5: `ready` rises exactly HOLD_CYC cycles after the last refresh. It then stays high with NOP on the bus until reset.
- R6: The mode write places burst length in `addr[2:0]`, burst type in `addr[3]` (1 = interleaved), the latency code in `addr[6:4]` and DLL reset in `addr[8]`. All other address bits are 0.
- R7: `cfgError` is 1 exactly when the burst length code is not 001/010/011 or the latency code is not 010/110. While it is 1 the sequencer holds NOP at the mode-write step, and it issues the mode write in the first cycle after the error clears.
- R8: `latHalf` is 4 for latency code 010 and 5 for code 110, with 2 added when `cfgRegistered` is 1. It is 0 for a reserved latency code.
- R9: A synchronous reset at any point returns the bus to deselect with `ready` low, and a later `pwrStable` restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwrStable | input | 1 | Power and clock are stable |
| cfgBurstLen | input | 3 | Burst length code |
| cfgBurstType | input | 1 | 0 sequential, 1 interleaved |
| cfgCasLat | input | 3 | CAS latency code |
| cfgDllReset | input | 1 | Request DLL reset in mode word |
| cfgRegistered | input | 1 | Module has a register stage on command/address |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 2 | Bank address |
| ready | output | 1 | Initialization complete |
| cfgError | output | 1 | Configuration uses a reserved code |
| latHalf | output | 4 | Effective read latency in half clock cycles |

## Verification
The assertions assume that the configuration inputs stay constant while the sequence runs, except while it is stalled at the mode-write step on a configuration error. They also assume that `pwrStable`, once high, stays high until the next reset. The stimulus sets the configuration only while the sequencer is in reset, in the power-wait state, or stalled at the mode-write step. It changes the configuration just after a rising edge so the new mode word is on the bus for the whole following cycle. It never drops `pwrStable` without also applying reset.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_EMRS,
    CMD_MRS,
    CMD_REF
  } cmdKind_e;

  typedef enum logic [2:0] {
    TM_SETTLE,
    TM_RP,
    TM_MRD,
    TM_RFC,
    TM_HOLD
  } tmrSel_e;

  typedef struct packed {
    cmdKind_e cmd;
    logic     tmrLoad;
    tmrSel_e  tmrSel;
    logic     refInc;
    logic     refClr;
  } seqStrobe_t;

endpackage

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SETTLE_CYC = 25000,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 9,
  parameter int HOLD_CYC   = 200,
  parameter int REF_N      = 2,
  parameter int TMR_W      = 15,
  parameter int REF_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgBurstType,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgDllReset,
  input  logic              cfgRegistered,
  output logic              tmrZero,
  output logic [REF_W-1:0]  refCnt,
  output logic              cfgError,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic [3:0]        latHalf
);

  localparam int A_AP = 10;

  logic [TMR_W-1:0]  tmr;
  logic [TMR_W-1:0]  loadVal;
  logic [ADDR_W-1:0] modeWord;
  logic              blOk;
  logic              clOk;
  logic [3:0]        latBase;

  // wait timer: a command state loads it, the wait state runs it down to zero
  always_comb begin
    case (strb.tmrSel)
      TM_SETTLE: loadVal = TMR_W'(SETTLE_CYC - 1);
      TM_RP:     loadVal = TMR_W'(T_RP - 2);
      TM_MRD:    loadVal = TMR_W'(T_MRD - 2);
      TM_RFC:    loadVal = TMR_W'(T_RFC - 2);
      TM_HOLD:   loadVal = TMR_W'(HOLD_CYC - 2);
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                tmr <= '0;
    else if (strb.tmrLoad)  tmr <= loadVal;
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst || strb.refClr) refCnt <= '0;
    else if (strb.refInc)   refCnt <= refCnt + 1'b1;
  end

  // mode word and its legality
  always_comb begin
    modeWord      = '0;
    modeWord[2:0] = cfgBurstLen;
    modeWord[3]   = cfgBurstType;
    modeWord[6:4] = cfgCasLat;
    modeWord[8]   = cfgDllReset;
  end

  assign blOk     = (cfgBurstLen == 3'b001) || (cfgBurstLen == 3'b010) || (cfgBurstLen == 3'b011);
  assign clOk     = (cfgCasLat == 3'b010) || (cfgCasLat == 3'b110);
  assign cfgError = !(blOk && clOk);

  always_comb begin
    case (cfgCasLat)
      3'b010:  latBase = 4'd4;
      3'b110:  latBase = 4'd5;
      default: latBase = 4'd0;
    endcase
    latHalf = (clOk && cfgRegistered) ? latBase + 4'd2 : latBase;
  end

  // command pins
  always_comb begin
    {csN, rasN, casN, weN} = 4'b0111;
    addr = '0;
    ba   = 2'b00;
    case (strb.cmd)
      CMD_DESEL: {csN, rasN, casN, weN} = 4'b1111;
      CMD_PRE: begin
        {csN, rasN, casN, weN} = 4'b0010;
        addr[A_AP] = 1'b1;
      end
      CMD_EMRS: begin
        {csN, rasN, casN, weN} = 4'b0000;
        ba = 2'b01;
      end
      CMD_MRS: begin
        {csN, rasN, casN, weN} = 4'b0000;
        addr = modeWord;
      end
      CMD_REF: {csN, rasN, casN, weN} = 4'b0001;
      default: {csN, rasN, casN, weN} = 4'b0111;
    endcase
  end

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
    strb.refInc |-> (refCnt < REF_W'(REF_N))) else $error("refresh count overrun"); // R3

  AST_LAT_VALID: assert property (@(posedge clk) disable iff (rst)
    !cfgError |-> (latHalf >= 4'd4 && latHalf <= 4'd7)) else $error("latency out of range"); // R8

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int REF_N = 2,
  parameter int REF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrStable,
  input  logic             tmrZero,
  input  logic [REF_W-1:0] refCnt,
  input  logic             cfgError,
  output seqStrobe_t       strb,
  output logic             ready
);

  typedef enum logic [3:0] {
    ST_PWR, ST_SETTLE, ST_PRE, ST_TRP, ST_EMRS, ST_TMRD1,
    ST_MRS, ST_TMRD2, ST_REF, ST_TRFC, ST_HOLD, ST_READY
  } seqState_e;

  seqState_e state, nextState;
  logic      lastRef;

  assign lastRef = (refCnt == REF_W'(REF_N - 1));

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PWR;
    else     state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb.cmd    = CMD_NOP;
    strb.tmrLoad = 1'b0;
    strb.tmrSel = TM_SETTLE;
    strb.refInc = 1'b0;
    strb.refClr = 1'b0;
    case (state)
      ST_PWR: begin
        strb.cmd = CMD_DESEL;
        if (pwrStable) begin
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = TM_SETTLE;
          nextState    = ST_SETTLE;
        end
      end
      ST_SETTLE: if (tmrZero) nextState = ST_PRE;
      ST_PRE: begin
        strb.cmd     = CMD_PRE;
        strb.tmrLoad = 1'b1;
        strb.tmrSel  = TM_RP;
        nextState    = ST_TRP;
      end
      ST_TRP: if (tmrZero) nextState = ST_EMRS;
      ST_EMRS: begin
        strb.cmd     = CMD_EMRS;
        strb.tmrLoad = 1'b1;
        strb.tmrSel  = TM_MRD;
        nextState    = ST_TMRD1;
      end
      ST_TMRD1: if (tmrZero) nextState = ST_MRS;
      ST_MRS: begin
        if (!cfgError) begin
          strb.cmd     = CMD_MRS;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = TM_MRD;
          strb.refClr  = 1'b1;
          nextState    = ST_TMRD2;
        end
      end
      ST_TMRD2: if (tmrZero) nextState = ST_REF;
      ST_REF: begin
        strb.cmd     = CMD_REF;
        strb.refInc  = 1'b1;
        strb.tmrLoad = 1'b1;
        if (lastRef) begin
          strb.tmrSel = TM_HOLD;
          nextState   = ST_HOLD;
        end else begin
          strb.tmrSel = TM_RFC;
          nextState   = ST_TRFC;
        end
      end
      ST_TRFC: if (tmrZero) nextState = ST_REF;
      ST_HOLD: if (tmrZero) nextState = ST_READY;
      ST_READY: nextState = ST_READY;
      default: nextState = ST_PWR;
    endcase
  end

  assign ready = (state == ST_READY);

  AST_CMD_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    (strb.cmd inside {CMD_PRE, CMD_EMRS, CMD_MRS, CMD_REF}) |-> $past(tmrZero))
    else $error("command issued before wait expired"); // R4

  AST_MRS_CFG_OK: assert property (@(posedge clk) disable iff (rst)
    (strb.cmd == CMD_MRS) |-> !cfgError) else $error("mode write with reserved code"); // R7

  AST_READY_AFTER_REFS: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (refCnt == REF_W'(REF_N))) else $error("ready before all refreshes"); // R5

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready) else $error("ready dropped"); // R5

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int SETTLE_US     = 200,
  parameter int T_RP          = 3,
  parameter int T_MRD         = 2,
  parameter int T_RFC         = 9,
  parameter int HOLD_CYC      = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrStable,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgBurstType,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgDllReset,
  input  logic              cfgRegistered,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              ready,
  output logic              cfgError,
  output logic [3:0]        latHalf
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int REF_N      = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
  localparam int MAX_A      = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int MAX_B      = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAX_C      = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int TMR_MAX    = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int REF_W      = $clog2(REF_N + 1);

  seqStrobe_t       strb;
  logic             tmrZero;
  logic [REF_W-1:0] refCnt;

  ddr_init_ctrl #(
    .REF_N (REF_N),
    .REF_W (REF_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pwrStable (pwrStable),
    .tmrZero   (tmrZero),
    .refCnt    (refCnt),
    .cfgError  (cfgError),
    .strb      (strb),
    .ready     (ready)
  );

  ddr_init_dp #(
    .ADDR_W     (ADDR_W),
    .SETTLE_CYC (SETTLE_CYC),
    .T_RP       (T_RP),
    .T_MRD      (T_MRD),
    .T_RFC      (T_RFC),
    .HOLD_CYC   (HOLD_CYC),
    .REF_N      (REF_N),
    .TMR_W      (TMR_W),
    .REF_W      (REF_W)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .cfgBurstLen   (cfgBurstLen),
    .cfgBurstType  (cfgBurstType),
    .cfgCasLat     (cfgCasLat),
    .cfgDllReset   (cfgDllReset),
    .cfgRegistered (cfgRegistered),
    .tmrZero       (tmrZero),
    .refCnt        (refCnt),
    .cfgError      (cfgError),
    .csN           (csN),
    .rasN          (rasN),
    .casN          (casN),
    .weN           (weN),
    .addr          (addr),
    .ba            (ba),
    .latHalf       (latHalf)
  );

  AST_READY_BUS_NOP: assert property (@(posedge clk) disable iff (rst)
    ready |-> ({csN, rasN, casN, weN} == 4'b0111)) else $error("bus busy while ready"); // R5

  AST_QUIET_UNTIL_PWR: assert property (@(posedge clk) disable iff (rst)
    (!ready && !pwrStable) |-> csN) else $error("command before power stable"); // R1

endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;

  localparam int B_SETTLE = 20;
  localparam int B_RP     = 3;
  localparam int B_MRD    = 2;
  localparam int B_RFC    = 8;
  localparam int B_HOLD   = 200;
  localparam int B_REFS   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwrStable = 1'b0;
  logic [2:0]  cfgBurstLen = 3'b010;
  logic        cfgBurstType = 1'b0;
  logic [2:0]  cfgCasLat = 3'b010;
  logic        cfgDllReset = 1'b0;
  logic        cfgRegistered = 1'b0;
  logic        csN, rasN, casN, weN;
  logic [11:0] addr;
  logic [1:0]  ba;
  logic        ready, cfgError;
  logic [3:0]  latHalf;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ(1), .SETTLE_US(B_SETTLE), .T_RP(B_RP), .T_MRD(B_MRD),
    .T_RFC(B_RFC), .HOLD_CYC(B_HOLD), .REFRESH_COUNT(B_REFS), .ADDR_W(12)
  ) uut (
    .clk(clk), .rst(rst), .pwrStable(pwrStable), .cfgBurstLen(cfgBurstLen),
    .cfgBurstType(cfgBurstType), .cfgCasLat(cfgCasLat), .cfgDllReset(cfgDllReset),
    .cfgRegistered(cfgRegistered), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .ba(ba), .ready(ready), .cfgError(cfgError), .latHalf(latHalf)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int logN = 0;
  int readyCyc = -1;
  logic [3:0]  logCmd  [16];
  logic [11:0] logAddr [16];
  logic [1:0]  logBa   [16];
  int          logCyc  [16];

  // bus monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!csN && {csN, rasN, casN, weN} != 4'b0111 && logN < 16) begin
      logCmd[logN]  = {csN, rasN, casN, weN};
      logAddr[logN] = addr;
      logBa[logN]   = ba;
      logCyc[logN]  = cyc;
      logN = logN + 1;
    end
    if (ready && readyCyc < 0) readyCyc = cyc;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stepNeg(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clearLog();
    logN = 0;
    readyCyc = -1;
  endtask

  task automatic doReset();
    stepNeg(1);
    rst = 1'b1;
    pwrStable = 1'b0;
    stepNeg(3);
    rst = 1'b0;
    clearLog();
  endtask

  function automatic int modeWordOf(input int bl, input int bt, input int cl, input int dll);
    return (dll << 8) + (cl << 4) + (bt << 3) + bl;
  endfunction

  task automatic waitReady();
    for (int i = 0; i < 1000 && readyCyc < 0; i++) stepNeg(1);
  endtask

  // checks refreshes from log index 3 on and the ready timing; e = MRS cycle
  task automatic checkTail(input int e);
    check(logN == 3 + B_REFS, "R3 command count", logN, 3 + B_REFS);
    for (int i = 0; i < B_REFS; i++) begin
      e = e + ((i == 0) ? B_MRD : B_RFC);
      check(logCmd[3 + i] == 4'b0001, "R3 refresh code", logCmd[3 + i], 1);
      check(logCyc[3 + i] == e, "R4 refresh spacing", logCyc[3 + i], e);
    end
    check(readyCyc == e + B_HOLD, "R5 ready timing", readyCyc, e + B_HOLD);
    stepNeg(15);
    check(ready == 1'b1, "R5 ready holds", ready, 1);
    check({csN, rasN, casN, weN} == 4'b0111, "R5 NOP while ready", {csN, rasN, casN, weN}, 7);
    check(logN == 3 + B_REFS, "R3 no command after ready", logN, 3 + B_REFS);
  endtask

  task automatic runAndVerify(input int bl, input int bt, input int cl, input int dll, input int rg);
    int startCyc;
    int e;
    stepNeg(1);
    cfgBurstLen = 3'(bl); cfgBurstType = 1'(bt); cfgCasLat = 3'(cl);
    cfgDllReset = 1'(dll); cfgRegistered = 1'(rg);
    clearLog();
    startCyc = cyc;
    pwrStable = 1'b1;
    waitReady();
    e = startCyc + 1 + B_SETTLE;
    check(logCyc[0] == e, "R2 settle length", logCyc[0], e);
    check(logCmd[0] == 4'b0010, "R3 precharge code", logCmd[0], 2);
    check(logAddr[0][10] == 1'b1, "R3 precharge all banks", logAddr[0][10], 1);
    e = e + B_RP;
    check(logCyc[1] == e, "R4 tRP gap", logCyc[1], e);
    check(logCmd[1] == 4'b0000 && logBa[1] == 2'b01 && logAddr[1] == 12'd0,
          "R3 extended mode write", logBa[1], 1);
    e = e + B_MRD;
    check(logCyc[2] == e, "R4 tMRD gap", logCyc[2], e);
    check(logCmd[2] == 4'b0000 && logBa[2] == 2'b00, "R3 mode write", logBa[2], 0);
    check(int'(logAddr[2]) == modeWordOf(bl, bt, cl, dll), "R6 mode word",
          logAddr[2], modeWordOf(bl, bt, cl, dll));
    checkTail(e);
  endtask

  task automatic t_resetState();
    doReset();
    check(csN == 1'b1, "R1 deselect after reset", csN, 1);
    check(ready == 1'b0, "R1 ready low after reset", ready, 0);
    stepNeg(40);
    check(logN == 0, "R1 no command without power", logN, 0);
    check(csN == 1'b1 && ready == 1'b0, "R1 still waiting", csN, 1);
  endtask

  task automatic t_configDecode();
    cfgBurstLen = 3'b001; cfgCasLat = 3'b010; cfgRegistered = 1'b0; #1;
    check(cfgError == 1'b0 && latHalf == 4'd4, "R8 CL2 unregistered", latHalf, 4);
    cfgCasLat = 3'b110; cfgRegistered = 1'b1; #1;
    check(cfgError == 1'b0 && latHalf == 4'd7, "R8 CL2.5 registered", latHalf, 7);
    cfgCasLat = 3'b011; #1;
    check(cfgError == 1'b1, "R7 reserved latency code", cfgError, 1);
    check(latHalf == 4'd0, "R8 reserved latency", latHalf, 0);
    cfgCasLat = 3'b010; cfgBurstLen = 3'b100; #1;
    check(cfgError == 1'b1, "R7 reserved burst code", cfgError, 1);
    cfgBurstLen = 3'b011; #1;
    check(cfgError == 1'b0 && latHalf == 4'd6, "R8 CL2 registered", latHalf, 6);
  endtask

  task automatic t_badConfig();
    int startCyc;
    int fixCyc;
    doReset();
    cfgBurstLen = 3'b000; cfgCasLat = 3'b010; cfgBurstType = 1'b0;
    cfgDllReset = 1'b1; cfgRegistered = 1'b0;
    stepNeg(1);
    startCyc = cyc;
    pwrStable = 1'b1;
    stepNeg(B_SETTLE + 40);
    check(logN == 2, "R7 stall before mode write", logN, 2);
    check(cfgError == 1'b1, "R7 error flagged", cfgError, 1);
    check({csN, rasN, casN, weN} == 4'b0111, "R7 NOP while stalled", {csN, rasN, casN, weN}, 7);
    fixCyc = cyc;
    @(posedge clk); #1;
    cfgBurstLen = 3'b011; cfgCasLat = 3'b110; cfgBurstType = 1'b1; cfgDllReset = 1'b0;
    waitReady();
    check(logCyc[2] == fixCyc + 1, "R7 mode write after fix", logCyc[2], fixCyc + 1);
    check(int'(logAddr[2]) == modeWordOf(3, 1, 6, 0), "R6 mode word after fix",
          logAddr[2], modeWordOf(3, 1, 6, 0));
    check(logCyc[0] == startCyc + 1 + B_SETTLE, "R2 settle with stall", logCyc[0], startCyc + 1 + B_SETTLE);
    checkTail(logCyc[2]);
  endtask

  task automatic t_midReset();
    int errBefore;
    doReset();
    cfgBurstLen = 3'b001; cfgCasLat = 3'b010;
    stepNeg(1);
    pwrStable = 1'b1;
    for (int i = 0; i < 200 && logN < 2; i++) stepNeg(1);
    rst = 1'b1;
    stepNeg(1);
    check(csN == 1'b1, "R9 deselect after mid reset", csN, 1);
    check(ready == 1'b0, "R9 ready low after mid reset", ready, 0);
    rst = 1'b0;
    pwrStable = 1'b0;
    clearLog();
    stepNeg(10);
    check(logN == 0, "R9 idle until power again", logN, 0);
    errBefore = errors;
    runAndVerify(3, 1, 6, 0, 0);
    check(errors == errBefore, "R9 clean restart", errors, errBefore);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_resetState();
    t_configDecode();
    doReset();
    runAndVerify(2, 0, 2, 1, 1);
    check(latHalf == 4'd6, "R8 latency after init", latHalf, 6);
    t_badConfig();
    t_midReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule